// File: doc/BRIEF.md
# Clock Buffer Two-Wire Configuration Slave

This block is the serial configuration port of a differential clock fan-out buffer. A two-wire bus host programs a six-byte register file through it, and the register bits are presented as parallel levels to the output-control logic. The port accepts four transfer types. Single-byte reads and writes reach any offset named in the command code. Counted block writes and reads always begin at byte zero and step upward one byte at a time.

The bus lines arrive as raw sampled levels. They pass through a synchronizer and are decoded for edges and for start and stop conditions, all in the system clock domain. The slave never drives the data line high. It has only an output-enable that pulls the line low for acknowledges and for zero data bits. A start or stop condition seen part way through a byte abandons the transfer, and the partial byte has no effect.

Top module: `clkbuf_smb_cfg`

## Requirements
- R1: After reset the bytes read 07h, FFh, 00h, 00h, 08h, 00h at offsets 0 to 5.
- R2: The slave acknowledges an address byte whose upper seven bits equal 6Eh, where bit 0 is the read flag (so DCh writes and DDh reads). For any other address it gives no acknowledge, and it ignores every following byte until the next start.
- R3: A command byte with bit 7 set selects single-byte mode, and its bits 6:0 are the offset. The next byte the host writes is stored at that offset and acknowledged. Any further data bytes are acknowledged and dropped. Registers change only on such writes.
- R4: In single-byte mode, a repeated start followed by the read address returns the byte at the commanded offset.
- R5: A command byte with bit 7 clear selects block mode. The next byte is a count. The data bytes that follow are written from offset 0 upward, but only as many as the count allows. Bytes beyond the count are acknowledged and not written.
- R6: A block read first returns the count 6, then bytes 0 to 5 in order. Any offset of 6 or above reads 00h, in both block and single-byte mode.
- R7: Offset 4 is read-only and always reads 08h. Offsets 3 and 5 and bits 5:3 of offset 0 always read 0. Writes to these bits are acknowledged and have no effect.
- R8: The parallel outputs map the register bits as follows. pd_tristate_o is byte 0 bit 7. stp_tristate_o is bit 6. high_bw_n_o is bit 2. pll_mode_o is bit 1. div2_n_o is bit 0. out_en_o is byte 1 and stoppable_o is byte 2.
- R9: A start or stop condition inside a byte aborts the transfer without any write, and a stop releases the data line.
- R10: When the host answers a read byte with no acknowledge, the slave stops driving the line until the next start or stop.
- R11: sda_o is held at 0, and sda_oe_o changes only just after a falling clock edge, or on a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level |
| sda_o | output | 1 | Data value driven when enabled (always 0) |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |
| pd_tristate_o | output | 1 | Power-down drive mode, 1 = float outputs |
| stp_tristate_o | output | 1 | Stop drive mode, 1 = float outputs |
| high_bw_n_o | output | 1 | 0 = high loop bandwidth |
| pll_mode_o | output | 1 | 0 = bypass, 1 = loop enabled |
| div2_n_o | output | 1 | 0 = halve the output frequency |
| out_en_o | output | 8 | Per-output enable |
| stoppable_o | output | 8 | Per-output stop-on-request flag |

## Verification
The bench builds the block with its default parameters. These are bus address 6Eh, ID byte 08h and a two-stage synchronizer. The bus is clocked with a quarter period of six system cycles, so every edge-detection and line-release latency sits inside one bus phase. With the default ID, the read-only check compares against a known nonzero value. Random offsets from 0 to 7 reach the two nonexistent offsets 6 and 7 as well as all six real bytes.

// File: rtl/clkbuf_smb_pkg.sv
package clkbuf_smb_pkg;
  localparam int REG_COUNT = 6;
  localparam int BYTE_W    = 8;
  localparam int PTR_W     = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WCNT, ST_WDATA,
    ST_SACK, ST_TX, ST_MACK, ST_IGNORE
  } link_state_e;

  function automatic logic [BYTE_W-1:0] reg_default(int idx, logic [BYTE_W-1:0] id);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hFF;
      4:       return id;
      default: return 8'h00;
    endcase
  endfunction

  // writable bits per byte
  function automatic logic [BYTE_W-1:0] reg_wmask(int idx);
    case (idx)
      0:       return 8'hC7;
      1:       return 8'hFF;
      2:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_lvl, sda_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_lvl;
      sda_d  <= sda_lvl;
    end
  end

  assign scl_lvl    = scl_ff[STAGES-1];
  assign sda_lvl    = sda_ff[STAGES-1];
  assign sda_lvl_o  = sda_lvl;
  assign scl_rise_o = scl_lvl & ~scl_d;
  assign scl_fall_o = ~scl_lvl & scl_d;
  assign start_o    = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_o     = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
  import clkbuf_smb_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [4:0]        mode_o,
  output logic [BYTE_W-1:0] en_o,
  output logic [BYTE_W-1:0] stop_o
);
  logic [BYTE_W-1:0] q [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] MASK = reg_wmask(g);
    localparam logic [BYTE_W-1:0] INIT = reg_default(g, ID_VALUE);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q[g] <= INIT;
      else if (we_i && addr_i == PTR_W'(g))
        q[g] <= (q[g] & ~MASK) | (wdata_i & MASK);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < REG_COUNT; i++)
      if (addr_i == PTR_W'(i)) rdata_o = q[i];
  end

  assign mode_o = {q[0][7:6], q[0][2:0]};
  assign en_o   = q[1];
  assign stop_o = q[2];
endmodule

// File: rtl/smb_link.sv
module smb_link
  import clkbuf_smb_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h6E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              we_o,
  output logic [PTR_W-1:0]  addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              sda_oe_o
);
  link_state_e state, nxt;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              blk, cnt_first, mack_ok, oe;
  logic [6:0]        offset;
  logic [PTR_W-1:0]  ptr, wr_left;
  logic              rx_state, byte_done;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == '1) ? p : p + 1'b1;
  endfunction

  assign rx_state  = (state == ST_ADDR) || (state == ST_CMD) ||
                     (state == ST_WCNT) || (state == ST_WDATA);
  assign byte_done = rx_state && scl_fall_i && (bit_cnt == 4'd8);

  assign we_o     = byte_done && (state == ST_WDATA) && (wr_left != '0);
  assign addr_o   = ptr;
  assign wdata_o  = shreg;
  assign sda_oe_o = oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      nxt       <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      blk       <= 1'b1;
      cnt_first <= 1'b0;
      mack_ok   <= 1'b0;
      oe        <= 1'b0;
      offset    <= '0;
      ptr       <= '0;
      wr_left   <= '0;
    end else if (start_i) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      oe      <= 1'b0;
    end else if (stop_i) begin
      state <= ST_IDLE;
      oe    <= 1'b0;
    end else begin
      if (rx_state && scl_rise_i && bit_cnt < 4'd8) begin
        shreg   <= {shreg[BYTE_W-2:0], sda_lvl_i};
        bit_cnt <= bit_cnt + 4'd1;
      end
      if (byte_done) begin
        oe    <= 1'b1;
        state <= ST_SACK;
        unique case (state)
          ST_ADDR: begin
            if (shreg[7:1] != SLV_ADDR) begin
              oe    <= 1'b0;
              state <= ST_IGNORE;
            end else if (shreg[0]) begin
              nxt       <= ST_TX;
              ptr       <= blk ? '0 : PTR_W'(offset);
              cnt_first <= blk;
            end else begin
              nxt <= ST_CMD;
            end
          end
          ST_CMD: begin
            blk     <= ~shreg[7];
            offset  <= shreg[6:0];
            ptr     <= shreg[7] ? PTR_W'(shreg[6:0]) : '0;
            wr_left <= shreg[7] ? PTR_W'(1) : '0;
            nxt     <= shreg[7] ? ST_WDATA : ST_WCNT;
          end
          ST_WCNT: begin
            wr_left <= PTR_W'(shreg);
            nxt     <= ST_WDATA;
          end
          default: begin
            if (wr_left != '0) begin
              wr_left <= wr_left - 1'b1;
              ptr     <= ptr_inc(ptr);
            end
            nxt <= ST_WDATA;
          end
        endcase
      end
      case (state)
        ST_SACK: if (scl_fall_i) begin
          bit_cnt <= '0;
          state   <= nxt;
          oe      <= 1'b0;
          if (nxt == ST_TX) begin
            cnt_first <= 1'b0;
            if (cnt_first) begin
              shreg <= BYTE_W'(REG_COUNT);
              oe    <= ~BYTE_W'(REG_COUNT) >> (BYTE_W-1) != 0;
            end else begin
              shreg <= rdata_i;
              oe    <= ~rdata_i[7];
              ptr   <= ptr_inc(ptr);
            end
          end
        end
        ST_TX: if (scl_fall_i) begin
          if (bit_cnt == 4'd7) begin
            oe      <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_MACK;
          end else begin
            bit_cnt <= bit_cnt + 4'd1;
            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
            oe      <= ~shreg[6];
          end
        end
        ST_MACK: begin
          if (scl_rise_i) mack_ok <= ~sda_lvl_i;
          if (scl_fall_i) begin
            if (mack_ok) begin
              shreg <= rdata_i;
              oe    <= ~rdata_i[7];
              ptr   <= ptr_inc(ptr);
              state <= ST_TX;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clkbuf_smb_cfg.sv
module clkbuf_smb_cfg
  import clkbuf_smb_pkg::*;
#(
  parameter logic [6:0]        SLV_ADDR    = 7'h6E,
  parameter logic [BYTE_W-1:0] ID_VALUE    = 8'h08,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe_o,
  output logic              pd_tristate_o,
  output logic              stp_tristate_o,
  output logic              high_bw_n_o,
  output logic              pll_mode_o,
  output logic              div2_n_o,
  output logic [BYTE_W-1:0] out_en_o,
  output logic [BYTE_W-1:0] stoppable_o
);
  logic              sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic              wr_en;
  logic [PTR_W-1:0]  reg_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [4:0]        mode;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_lvl_o (sda_lvl),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  smb_link #(.SLV_ADDR(SLV_ADDR)) u_link (
    .clk_i, .rst_ni,
    .sda_lvl_i (sda_lvl),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (bus_start),
    .stop_i    (bus_stop),
    .rdata_i   (rd_data),
    .we_o      (wr_en),
    .addr_o    (reg_addr),
    .wdata_o   (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  smb_cfg_bank #(.ID_VALUE(ID_VALUE)) u_bank (
    .clk_i, .rst_ni,
    .we_i   (wr_en),
    .addr_i (reg_addr),
    .wdata_i(wr_data),
    .rdata_o(rd_data),
    .mode_o (mode),
    .en_o   (out_en_o),
    .stop_o (stoppable_o)
  );

  assign sda_o = 1'b0;
  assign {pd_tristate_o, stp_tristate_o, high_bw_n_o, pll_mode_o, div2_n_o} = mode;
endmodule

// File: rtl/clkbuf_smb_cfg_chk.sv
module clkbuf_smb_cfg_chk
  import clkbuf_smb_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'h08
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_o,
  input logic              sda_oe_i,
  input logic              scl_fall_i,
  input logic              start_i,
  input logic              stop_i,
  input logic              we_i,
  input logic [PTR_W-1:0]  addr_i,
  input logic [BYTE_W-1:0] rdata_i,
  input logic [20:0]       cfg_i
);
  AST_OE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i))); // R11
  AST_DRIVE_LOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_i |-> !sda_o); // R11
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i); // R9
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_i)); // R3
  AST_ID_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == PTR_W'(4)) |-> (rdata_i == ID_VALUE)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i == PTR_W'(3)) || (addr_i == PTR_W'(5))) |-> (rdata_i == '0)); // R7
  AST_RSVD_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (rdata_i[5:3] == 3'b000)); // R7
  AST_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= PTR_W'(REG_COUNT)) |-> (rdata_i == '0)); // R6
endmodule

bind clkbuf_smb_cfg clkbuf_smb_cfg_chk #(.ID_VALUE(ID_VALUE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_o     (sda_o),
  .sda_oe_i  (sda_oe_o),
  .scl_fall_i(scl_fall),
  .start_i   (bus_start),
  .stop_i    (bus_stop),
  .we_i      (wr_en),
  .addr_i    (reg_addr),
  .rdata_i   (rd_data),
  .cfg_i     ({mode, out_en_o, stoppable_o})
);

// File: tb/clkbuf_smb_cfg_tb.sv
module clkbuf_smb_cfg_tb;
  localparam int Q = 6;
  localparam logic [7:0] AW = 8'hDC;
  localparam logic [7:0] AR = 8'hDD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_o, sda_oe;
  logic pd_ts, stp_ts, hbw_n, pll_m, div2_n;
  logic [7:0] out_en, stoppable;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [6];
  logic [7:0] rbuf [10];

  always #2 clk = ~clk;

  clkbuf_smb_cfg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe_o(sda_oe),
    .pd_tristate_o(pd_ts), .stp_tristate_o(stp_ts), .high_bw_n_o(hbw_n),
    .pll_mode_o(pll_m), .div2_n_o(div2_n),
    .out_en_o(out_en), .stoppable_o(stoppable)
  );

  function automatic logic [7:0] f_mask(int i);
    case (i) 0: return 8'hC7; 1, 2: return 8'hFF; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] f_dflt(int i);
    case (i) 0: return 8'h07; 1: return 8'hFF; 4: return 8'h08; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] f_rd(int i);
    return (i < 6) ? mdl[i] : 8'h00;
  endfunction
  task automatic mdl_wr(int i, logic [7:0] d);
    if (i < 6) mdl[i] = (mdl[i] & ~f_mask(i)) | (d & f_mask(i));
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " mode"}, {3'b0, pd_ts, stp_ts, hbw_n, pll_m, div2_n},
        {3'b0, mdl[0][7:6], mdl[0][2:0]});
    chk({tag, " out_en"}, out_en, mdl[1]);
    chk({tag, " stoppable"}, stoppable, mdl[2]);
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask
  task automatic bit_out(logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask
  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask
  task automatic send(logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask
  task automatic recv(output logic [7:0] b, input logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
    bit_out(~ack);
  endtask

  task automatic byte_wr(int off, logic [7:0] d, string tag);
    logic a0, a1, a2;
    bus_start(); send(AW, a0); send(8'h80 | 8'(off), a1); send(d, a2); bus_stop();
    chk({tag, " ack"}, {5'b0, a0, a1, a2}, 8'h07);
  endtask
  task automatic byte_rd(int off, output logic [7:0] d, input string tag);
    logic a0, a1, a2;
    bus_start(); send(AW, a0); send(8'h80 | 8'(off), a1);
    bus_start(); send(AR, a2); recv(d, 1'b0); bus_stop();
    chk({tag, " ack"}, {5'b0, a0, a1, a2}, 8'h07);
  endtask
  task automatic blk_rd(int n, string tag);
    logic a0, a1, a2;
    bus_start(); send(AW, a0); send(8'h00, a1);
    bus_start(); send(AR, a2);
    for (int i = 0; i < n; i++) recv(rbuf[i], i != n - 1);
    bus_stop();
    chk({tag, " ack"}, {5'b0, a0, a1, a2}, 8'h07);
  endtask
  task automatic blk_check(string tag);
    blk_rd(9, tag);
    chk({tag, " count"}, rbuf[0], 8'd6);
    for (int i = 0; i < 8; i++) chk($sformatf("%s byte%0d", tag, i), rbuf[i+1], f_rd(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a0, a1, a2, a3, v;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 6; i++) mdl[i] = f_dflt(i);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    wq();

    // R1 R8 reset state at the ports, R11 line idle
    chk_outs("R1/R8 reset");
    chk("R11 sda_o", {7'b0, sda_o}, 8'h00);
    chk("R11 oe idle", {7'b0, sda_oe}, 8'h00);
    // R1 R6 defaults through a block read, including past-end bytes
    blk_check("R1/R6 blkrd");

    // R3 R4 R8 single-byte write and read back
    byte_wr(1, 8'h5A, "R3 wr"); mdl_wr(1, 8'h5A);
    byte_rd(1, d, "R4 rd"); chk("R4 data", d, 8'h5A);
    chk_outs("R8 after wr");

    // R7 masked bits
    byte_wr(0, 8'hFF, "R7 wr0"); mdl_wr(0, 8'hFF);
    byte_rd(0, d, "R7 rd0"); chk("R7 byte0", d, 8'hC7);
    byte_wr(4, 8'h00, "R7 wr4");
    byte_rd(4, d, "R7 rd4"); chk("R7 id", d, 8'h08);
    byte_wr(3, 8'hFF, "R7 wr3");
    byte_rd(3, d, "R7 rd3"); chk("R7 byte3", d, 8'h00);
    chk_outs("R8 byte0 all set");

    // R3 extra data in single-byte mode dropped
    bus_start(); send(AW, a0); send(8'h82, a1); send(8'h3C, a2); send(8'hA5, a3); bus_stop();
    chk("R3 extra ack", {4'b0, a0, a1, a2, a3}, 8'h0F);
    mdl_wr(2, 8'h3C);
    byte_rd(3, d, "R3 rd3"); chk("R3 extra dropped", d, 8'h00);
    chk_outs("R3 outs");

    // R5 block write count 2, third byte acked but not written
    bus_start(); send(AW, a0); send(8'h00, a1); send(8'h02, a2); send(8'h40, a3);
    chk("R5 hdr ack", {4'b0, a0, a1, a2, a3}, 8'h0F);
    send(8'h0F, a0); send(8'h99, a1); bus_stop();
    chk("R5 tail ack", {6'b0, a0, a1}, 8'h03);
    mdl_wr(0, 8'h40); mdl_wr(1, 8'h0F);
    blk_check("R5 blk");
    chk_outs("R5 outs");

    // R2 wrong address: no ack, following bytes ignored
    bus_start(); send(8'hB8, a0); send(8'h81, a1); send(8'h00, a2); bus_stop();
    chk("R2 nack", {5'b0, a0, a1, a2}, 8'h00);
    chk_outs("R2 unchanged");
    bus_start(); send(8'hDE, a0); bus_stop();
    chk("R2 near addr", {7'b0, a0}, 8'h00);

    // R9 stop mid data byte
    bus_start(); send(AW, a0); send(8'h82, a1);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    chk("R9 stop oe", {7'b0, sda_oe}, 8'h00);
    chk_outs("R9 stop abort");
    // R9 repeated start mid data byte, then an unrelated read
    bus_start(); send(AW, a0); send(8'h81, a1);
    for (int i = 0; i < 5; i++) bit_out(1'b0);
    bus_start(); send(AR, a2); recv(d, 1'b0); bus_stop();
    chk("R9 start abort data", d, mdl[1]);
    chk_outs("R9 start abort");

    // R10 nack after count: line left released
    bus_start(); send(AW, a0); send(8'h00, a1); bus_start(); send(AR, a2);
    recv(d, 1'b0);
    chk("R10 count", d, 8'd6);
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin bit_in(v); d[i] = v; end
    bus_stop();
    chk("R10 released", d, 8'hFF);

    // R6 single-byte read beyond the file
    byte_rd(7, d, "R6 rd7"); chk("R6 past end", d, 8'h00);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int off, off2;
      logic [7:0] wd;
      off = int'($urandom % 8);
      off2 = int'($urandom % 8);
      wd = 8'($urandom);
      byte_wr(off, wd, "R3 rnd wr"); mdl_wr(off, wd);
      byte_rd(off2, d, "R4 rnd rd"); chk("R4 rnd data", d, f_rd(off2));
      chk_outs("R8 rnd");
      if (it % 8 == 7) blk_check("R6 rnd blk");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule